// File: doc/BRIEF.md
# Serial ADC Command and Result Port

This block is the digital side of an 8-channel, 12-bit converter's serial port, run from a host-supplied serial clock. While the host holds the chip-select low, it shifts a command byte into the data input on rising serial-clock edges. The command picks a channel, unipolar or bipolar coding and the operating mode. The block then raises a strobe for one serial-clock period and sends the 12-bit result out, most significant bit first, on falling edges. A parallel sample bus, with one 12-bit word per channel, stands in for the analog converter.

Conversions repeat every 15 serial clocks. The next command byte may start as soon as the current frame's 15 clocks have elapsed, so its first bits overlap the tail of the previous result. All logic runs on a fast system clock `clk`. The serial inputs must be synchronous to `clk`, and each serial-clock phase must last at least two `clk` cycles. Serial-clock edges are found by comparing the input with its registered copy.

The receiver FSM has three states:
- RX_IDLE searches for a start bit and moves to RX_CMD when it sees one.
- RX_CMD collects the command byte. It moves to RX_HOLD when the command is accepted and back to RX_IDLE when it is rejected.
- RX_HOLD waits out the rest of the 15-clock frame and returns to RX_IDLE.

The transmitter FSM has four states:
- TX_IDLE moves to TX_ARM when a conversion is launched.
- TX_ARM moves to TX_STRB on the next falling edge.
- TX_STRB moves to TX_SHIFT on the falling edge after that.
- TX_SHIFT returns to TX_IDLE after the 12th bit.

A high chip-select forces both FSMs to their idle states.

Top module: `sadc_port`

## Requirements
- R1: After reset, with chip-select high, `sstrb_o`, `dout_o` and `dout_oe_o` are all 0.
- R2: While `cs_n_i` is low, zeros on `din_i` at rising serial-clock edges are ignored in the idle state. The first 1 sampled is the start bit and counts as serial clock 1 of a frame.
- R3: The command byte occupies serial clocks 1 to 8, sent MSB first, and has the following fields:
  - bit 7 is the start bit;
  - bits 6:4 are the channel number in plain binary;
  - bit 3 is the coding (1 = unipolar, 0 = bipolar);
  - bit 2 is the input mode (1 = single-ended);
  - bits 1:0 are the mode bits.

  A conversion starts only when bit 2 is 1 and bits 1:0 are 11. Any other byte produces no strobe.
- R4: On the falling edge of serial clock 8 of an accepted frame, `sstrb_o` goes high. It goes low again at the next falling edge, so it stays high for exactly one serial-clock period.
- R5: The result bits appear on `dout_o` MSB first, one per falling edge, on falling edges 9 through 20. At falling edge 21, `dout_o` returns to 0.
- R6: In unipolar coding, the result is the sample word of the selected channel as it stood at rising edge 8. A full-scale sample of 0xFFF returns 0xFFF.
- R7: In bipolar coding, the result is the selected sample word with its MSB inverted.
- R8: After the command byte, `din_i` is ignored through rising edge 15. A start bit is accepted again from rising edge 16 onward. With `din_i` held at 1, a conversion therefore occurs every 15 serial clocks.
- R9: While `cs_n_i` is high, `dout_oe_o` and `sstrb_o` are 0. A frame in progress when chip-select rises is dropped, and the next start bit after chip-select falls begins a fresh frame.
- R10: While chip-select stays low, `sstrb_o` and `dout_o` change only in the `clk` cycle that follows a detected falling edge of the serial clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip-select, active low |
| sclk_i | input | 1 | Serial clock from the host |
| din_i | input | 1 | Serial command data in |
| sample_i | input | 96 | Per-channel sample words; channel c is bits [12c+11:12c] |
| dout_o | output | 1 | Serial result data out |
| dout_oe_o | output | 1 | Output enable for `dout_o` (0 means high impedance) |
| sstrb_o | output | 1 | Strobe placed one period before the result MSB |

## Verification
The hardest situation to reach is the overlap of frames. The next command byte must begin on rising edge 16 while the previous result is still shifting out, and the ones on `din_i` during the hold window must be ignored rather than taken as start bits. The stimulus reaches this by holding `din_i` high across back-to-back all-ones command bytes, each carrying a different sample on channel 7. Any error in the hold count shifts the strobe away from its expected falling edge. A chip-select abort in the middle of a command byte, followed by a fresh frame, shows whether stale receiver state survives the abort.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
    typedef enum logic [1:0] {
        RX_IDLE,
        RX_CMD,
        RX_HOLD
    } rx_state_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_ARM,
        TX_STRB,
        TX_SHIFT
    } tx_state_e;

    localparam logic [1:0] MODE_EXT_RUN = 2'b11;
endpackage

// File: rtl/sadc_rx.sv
module sadc_rx
    import sadc_pkg::*;
#(
    parameter int CMD_BITS   = 8,
    parameter int FRAME_CLKS = 15,
    parameter int CH_W       = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            rise,
    input  logic            din,
    output logic            go_o,
    output logic [CH_W-1:0] chan_o,
    output logic            unipolar_o
);
    localparam int BODY_W = CMD_BITS - 1;
    localparam int CNT_W  = $clog2(FRAME_CLKS + 1);

    rx_state_e          state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [BODY_W-2:0]  body_q;
    logic [BODY_W-1:0]  body;
    logic               accept;

    // body bits: [BODY_W-1 -: CH_W] channel, then coding, input mode, mode pair
    assign body   = {body_q, din};
    assign accept = body[2] && (body[1:0] == MODE_EXT_RUN);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: if (rise && din) state_d = RX_CMD;
            RX_CMD:  if (rise && cnt_q == CNT_W'(CMD_BITS - 1))
                         state_d = accept ? RX_HOLD : RX_IDLE;
            RX_HOLD: if (rise && cnt_q == CNT_W'(FRAME_CLKS - 1))
                         state_d = RX_IDLE;
            default: state_d = RX_IDLE;
        endcase
        if (cs_n) state_d = RX_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            body_q     <= '0;
            go_o       <= 1'b0;
            chan_o     <= '0;
            unipolar_o <= 1'b0;
        end else begin
            go_o <= 1'b0;
            if (cs_n) begin
                cnt_q <= '0;
            end else if (rise) begin
                unique case (state_q)
                    RX_IDLE: cnt_q <= CNT_W'(1);
                    RX_CMD: begin
                        cnt_q  <= cnt_q + CNT_W'(1);
                        body_q <= body[BODY_W-2:0];
                        if (state_d == RX_HOLD) begin
                            go_o       <= 1'b1;
                            chan_o     <= body[BODY_W-1 -: CH_W];
                            unipolar_o <= body[3];
                        end
                    end
                    RX_HOLD: cnt_q <= cnt_q + CNT_W'(1);
                    default: cnt_q <= '0;
                endcase
            end
        end
    end

    a_r9_cs_idles_rx: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> state_q == RX_IDLE);
    a_r8_hold_window: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == RX_HOLD |-> (cnt_q >= CNT_W'(CMD_BITS) && cnt_q <= CNT_W'(FRAME_CLKS - 1)));
    a_r3_go_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        go_o |-> state_q == RX_HOLD);
endmodule

// File: rtl/sadc_tx.sv
module sadc_tx
    import sadc_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             fall,
    input  logic             go,
    input  logic [RES_W-1:0] result_i,
    output logic             sstrb_o,
    output logic             dout_o
);
    localparam int BIT_W = $clog2(RES_W + 1);

    tx_state_e         state_q, state_d;
    logic [RES_W-1:0]  sr_q;
    logic [BIT_W-1:0]  bit_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (go) state_d = TX_ARM;
            TX_ARM:   if (fall) state_d = TX_STRB;
            TX_STRB:  if (fall) state_d = TX_SHIFT;
            TX_SHIFT: if (fall && bit_q == BIT_W'(RES_W)) state_d = TX_IDLE;
            default:  state_d = TX_IDLE;
        endcase
        if (cs_n) state_d = TX_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q    <= '0;
            bit_q   <= '0;
            dout_o  <= 1'b0;
            sstrb_o <= 1'b0;
        end else if (cs_n) begin
            bit_q   <= '0;
            dout_o  <= 1'b0;
            sstrb_o <= 1'b0;
        end else begin
            sstrb_o <= (state_d == TX_STRB);
            if (state_q == TX_IDLE && go) begin
                sr_q  <= result_i;
                bit_q <= '0;
            end else if (fall && (state_q == TX_STRB || state_q == TX_SHIFT)) begin
                if (state_d == TX_IDLE) begin
                    dout_o <= 1'b0;
                end else begin
                    dout_o <= sr_q[RES_W-1];
                    sr_q   <= {sr_q[RES_W-2:0], 1'b0};
                    bit_q  <= bit_q + BIT_W'(1);
                end
            end
        end
    end

    a_r4_strobe_one_period: assert property (@(posedge clk) disable iff (!rst_n)
        (sstrb_o && fall && !cs_n) |=> !sstrb_o);
    a_r10_dout_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !fall) |=> $stable(dout_o));
    a_r10_strobe_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !fall) |=> $stable(sstrb_o));
    a_r9_cs_clears_tx: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!sstrb_o && !dout_o && state_q == TX_IDLE));
endmodule

// File: rtl/sadc_port.sv
module sadc_port #(
    parameter int CHANNELS   = 8,
    parameter int RES_W      = 12,
    parameter int CMD_BITS   = 8,
    parameter int FRAME_CLKS = 15
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cs_n_i,
    input  logic                      sclk_i,
    input  logic                      din_i,
    input  logic [CHANNELS*RES_W-1:0] sample_i,
    output logic                      dout_o,
    output logic                      dout_oe_o,
    output logic                      sstrb_o
);
    localparam int CH_W = $clog2(CHANNELS);

    logic            sclk_q, oe_q;
    logic            rise, fall;
    logic            go;
    logic [CH_W-1:0] chan;
    logic            unipolar;
    logic [RES_W-1:0] picked, result;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            oe_q   <= 1'b0;
        end else begin
            sclk_q <= sclk_i;
            oe_q   <= !cs_n_i;
        end
    end

    assign rise      = sclk_i && !sclk_q;
    assign fall      = !sclk_i && sclk_q;
    assign dout_oe_o = oe_q;

    assign picked = sample_i[chan*RES_W +: RES_W];
    assign result = unipolar ? picked : {~picked[RES_W-1], picked[RES_W-2:0]};

    sadc_rx #(
        .CMD_BITS   (CMD_BITS),
        .FRAME_CLKS (FRAME_CLKS),
        .CH_W       (CH_W)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n_i),
        .rise       (rise),
        .din        (din_i),
        .go_o       (go),
        .chan_o     (chan),
        .unipolar_o (unipolar)
    );

    sadc_tx #(
        .RES_W (RES_W)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n_i),
        .fall     (fall),
        .go       (go),
        .result_i (result),
        .sstrb_o  (sstrb_o),
        .dout_o   (dout_o)
    );

    a_r9_oe_follows_cs: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_i |=> !dout_oe_o);
endmodule

// File: tb/sadc_port_tb.sv
module sadc_port_tb;
    logic clk = 1'b0;
    logic rst_n, cs_n, sclk, din;
    logic [11:0] samp [8];
    logic [95:0] sample_bus;
    logic dout, dout_oe, sstrb;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 8; i++) sample_bus[i*12 +: 12] = samp[i];
    end

    sadc_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_i    (cs_n),
        .sclk_i    (sclk),
        .din_i     (din),
        .sample_i  (sample_bus),
        .dout_o    (dout),
        .dout_oe_o (dout_oe),
        .sstrb_o   (sstrb)
    );

    typedef struct {
        int         idx;
        logic [11:0] val;
        bit         bip;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0, bad = 0, rise_n = 0, strobes = 0;
    bit   done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic sclk_cycle(input logic d);
        @(negedge clk);
        din = d;
        repeat (4) @(negedge clk);
        sclk = 1'b1;
        rise_n++;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
    endtask

    // one 15-clock frame: 8 command bits then 7 pad bits
    task automatic send_frame(input logic [7:0] cmd, input logic pad);
        exp_t e;
        logic [11:0] v;
        if (cmd[2] && cmd[1:0] == 2'b11) begin
            v = samp[cmd[6:4]];
            if (!cmd[3]) v[11] = ~v[11];
            e.idx = rise_n + 8;
            e.val = v;
            e.bip = !cmd[3];
            exp_q.push_back(e);
        end
        for (int i = 7; i >= 0; i--) sclk_cycle(cmd[i]);
        for (int i = 0; i < 7; i++) sclk_cycle(pad);
    endtask

    // monitor: falling-edge samples
    logic last_s, last_d;
    bit   lvalid = 0;
    initial begin
        int   mstate = 0, bitpos = 0;
        exp_t cur;
        cur.idx = 0; cur.val = '0; cur.bip = 0;
        forever begin
            @(negedge sclk);
            repeat (2) @(posedge clk);
            #1;
            if (cs_n) begin
                mstate = 0;
                lvalid = 0;
            end else begin
                unique case (mstate)
                    0: if (sstrb) begin
                        strobes++;
                        if (exp_q.size() == 0) begin
                            chk(0, "R3 unexpected strobe", rise_n, 0);
                        end else begin
                            cur = exp_q.pop_front();
                            chk(rise_n == cur.idx, "R4 strobe edge", rise_n, cur.idx);
                            mstate = 1;
                            bitpos = 11;
                        end
                    end
                    1: begin
                        chk(sstrb == 1'b0, "R4 strobe width", int'(sstrb), 0);
                        if (cur.bip)
                            chk(dout == cur.val[bitpos], "R7 bipolar bit", int'(dout), int'(cur.val[bitpos]));
                        else
                            chk(dout == cur.val[bitpos], "R5 R6 result bit", int'(dout), int'(cur.val[bitpos]));
                        if (bitpos == 0) mstate = 2;
                        else bitpos--;
                    end
                    default: begin
                        chk(dout == 1'b0, "R5 dout after lsb", int'(dout), 0);
                        mstate = 0;
                    end
                endcase
                last_s = sstrb;
                last_d = dout;
                lvalid = 1;
            end
        end
    end

    // monitor: outputs must hold across rising edges
    initial begin
        forever begin
            @(posedge sclk);
            repeat (2) @(posedge clk);
            #1;
            if (cs_n) lvalid = 0;
            else if (lvalid)
                chk(sstrb == last_s && dout == last_d, "R10 outputs held",
                    {sstrb, dout}, {last_s, last_d});
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        finish_up();
    end

    initial begin
        int s0;
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; din = 1'b0;
        for (int i = 0; i < 8; i++) samp[i] = 12'h000;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(sstrb == 0 && dout == 0 && dout_oe == 0, "R1 reset state", {sstrb, dout, dout_oe}, 0);

        cs_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(dout_oe == 1'b1, "R9 oe on cs low", int'(dout_oe), 1);

        // R2: leading zeros ignored before start bit
        for (int i = 0; i < 3; i++) sclk_cycle(1'b0);

        // R8/R6: din held high, back-to-back conversions on channel 7
        samp[7] = 12'hFFF; send_frame(8'hFF, 1'b1);
        samp[7] = 12'h000; send_frame(8'hFF, 1'b1);
        samp[7] = 12'hA5C; send_frame(8'hFF, 1'b1);
        samp[7] = 12'h5A3; send_frame(8'hFF, 1'b1);
        samp[7] = 12'h001; send_frame(8'hFF, 1'b1);
        samp[7] = 12'h800; send_frame(8'hFF, 1'b0);

        // R7: bipolar on channel 2; R3: channel field on 5 unipolar
        samp[2] = 12'h3C4; send_frame(8'hA7, 1'b0);
        samp[5] = 12'h8E1; send_frame(8'hDF, 1'b0);
        samp[0] = 12'h0F0; send_frame(8'h8F, 1'b0);

        // R3: rejected mode bits and differential mode give no strobe
        s0 = strobes;
        for (int i = 0; i < 6; i++) sclk_cycle(1'b0);
        s0 = strobes;
        send_frame(8'hFC, 1'b0);
        send_frame(8'hFB, 1'b0);
        for (int i = 0; i < 4; i++) sclk_cycle(1'b0);
        chk(strobes == s0, "R3 no conversion", strobes, s0);

        // R9: abort mid command byte, then a fresh frame
        sclk_cycle(1'b1); sclk_cycle(1'b1); sclk_cycle(1'b0); sclk_cycle(1'b1);
        @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(dout_oe == 1'b0, "R9 oe off", int'(dout_oe), 0);
        chk(sstrb == 1'b0, "R9 strobe low", int'(sstrb), 0);
        sclk_cycle(1'b1); sclk_cycle(1'b1);
        @(negedge clk);
        cs_n = 1'b0;
        repeat (3) @(negedge clk);
        samp[7] = 12'h7E7; send_frame(8'hFF, 1'b0);

        for (int i = 0; i < 20; i++) sclk_cycle(1'b0);
        chk(exp_q.size() == 0, "R4 all strobes seen", exp_q.size(), 0);
        finish_up();
    end
endmodule